// File: doc/BRIEF.md
# Pattern-Toggled Serial Complement Encoder

The block scrambles a serial bitstream with a simple two-mode rule. It takes one data bit per clock and returns one bit in the same cycle. In pass mode the returned bit is the incoming bit unchanged. In complement mode it is the inverted incoming bit. The block watches the raw incoming stream for two 3-bit patterns. One pattern arms the complement mode and a different one disarms it. The output is a Mealy function: it depends on the registered state and on the live input bit, with no register in between.

The state lives in three D flip-flops and uses six codes. One bit holds the mode. Two bits hold how far the stream has progressed toward the pattern that matters in that mode. Patterns may overlap. The bits that complete one pattern count toward the next one. A mode change applies from the bit that follows the completing bit. A flag output shows the mode that applies to the current bit. Reset is asserted asynchronously and active low, and it is released through an internal synchronizer.

Top module: `bitstream_toggle_encoder`

## Requirements
- R1: While reset is asserted, and after it is released, the block is in pass mode: `inv_mode` is 0 and `dout` equals `din`.
- R2: In pass mode, the input bits 1, 1, 0 on consecutive clocks switch the block to complement mode. The 0 that completes the pattern is still passed unchanged. The switch takes effect from the next bit.
- R3: In complement mode, `dout` is the logical inverse of `din`, and `inv_mode` reads 1.
- R4: In complement mode, the input bits 0, 1, 0 on consecutive clocks switch the block back to pass mode. The completing 0 is still inverted, and pass mode applies from the next bit.
- R5: Pattern search allows overlap. A run of three or more 1s followed by a 0 triggers complement mode on that 0.
- R6: Input history carries across a switch. The 0 that completes the pass-to-complement pattern can serve as the first bit of the release pattern, so 1,1,0,1,0 enters complement mode and leaves it again on its last bit.
- R7: Only the pattern for the present mode is searched. In pass mode 0,1,0 has no effect, and in complement mode 1,1,0 has no effect.
- R8: Starting from reset, the input 0111010001110101 (first bit first) yields the output 0111001001110011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one data bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| din | input | 1 | Serial input bit for the current cycle |
| dout | output | 1 | Encoded bit for the current cycle (combinational from din) |
| inv_mode | output | 1 | 1 when the current bit is being complemented |

## Verification
The assertions check the state transitions on every cycle:
- the trigger step into complement mode,
- the release step back to pass mode,
- the overlap hold while 1s keep arriving,
- the rule that a 1 input never changes the mode,
- the rule that the unused progress code never appears.

Only the bench scenarios can show the externally visible results:
- the exact output of a whole reference stream,
- the completing bit still being encoded in the old mode,
- the reuse of the trigger's final 0 by the release pattern,
- the immunity of each mode to the other mode's pattern,
- the immediate return to pass mode when reset is asserted mid-stream.

// File: rtl/enc_pkg.sv
package enc_pkg;

  localparam int STATE_W = 3;
  localparam int PROG_W  = 2;

  // bit 2 = mode (1 = complement), bits 1:0 = pattern progress
  typedef enum logic [STATE_W-1:0] {
    ST_P0 = 3'b000,  // pass, no progress toward 1,1,0
    ST_P1 = 3'b001,  // pass, seen 1
    ST_P2 = 3'b010,  // pass, seen 1,1
    ST_C0 = 3'b100,  // complement, no progress toward 0,1,0
    ST_C1 = 3'b101,  // complement, seen 0
    ST_C2 = 3'b110   // complement, seen 0,1
  } enc_state_e;

  localparam int MODE_BIT = STATE_W - 1;

endpackage

// File: rtl/enc_rst_sync.sv
module enc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/enc_next_state.sv
module enc_next_state
  import enc_pkg::*;
(
  input  enc_state_e state_q,
  input  logic       din,
  output enc_state_e state_d
);

  always_comb begin
    state_d = ST_P0;
    unique case (state_q)
      // pass mode: hunt for 1,1,0
      ST_P0:   state_d = din ? ST_P1 : ST_P0;
      ST_P1:   state_d = din ? ST_P2 : ST_P0;
      ST_P2:   state_d = din ? ST_P2 : ST_C1;  // trailing 0 counts as first bit of 0,1,0
      // complement mode: hunt for 0,1,0
      ST_C0:   state_d = din ? ST_C0 : ST_C1;
      ST_C1:   state_d = din ? ST_C2 : ST_C1;
      ST_C2:   state_d = din ? ST_C0 : ST_P0;  // history "1,0" gives no 1,1,0 progress
      default: state_d = ST_P0;                // unused codes fall back to idle
    endcase
  end

endmodule

// File: rtl/enc_state_reg.sv
module enc_state_reg
  import enc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       din,
  input  enc_state_e state_d,
  output enc_state_e state_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_P0;
    end else begin
      state_q <= state_d;
    end
  end

  // R2: last bit of 1,1,0 moves to complement with one 0 already counted
  a_r2_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_P2 && !din) |=> (state_q == ST_C1));

  // R4: last bit of 0,1,0 returns to idle pass mode
  a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_C2 && !din) |=> (state_q == ST_P0));

  // R5: extra 1s keep the 1,1 progress (overlap)
  a_r5_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_P2 && din) |=> (state_q == ST_P2));

  // R7: a 1 input never changes the mode in either direction
  a_r7_pass_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (!state_q[MODE_BIT] && din) |=> !state_q[MODE_BIT]);

  a_r7_comp_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q[MODE_BIT] && din) |=> state_q[MODE_BIT]);

  // R1: only the six legal codes are ever held
  a_r1_legal: assert property (@(posedge clk) disable iff (!rst_n)
    state_q[PROG_W-1:0] != 2'b11);

endmodule

// File: rtl/enc_out.sv
module enc_out
  import enc_pkg::*;
(
  input  enc_state_e state_q,
  input  logic       din,
  output logic       dout,
  output logic       inv_mode
);

  always_comb begin
    inv_mode = state_q[MODE_BIT];
    dout     = inv_mode ? ~din : din;
  end

endmodule

// File: rtl/bitstream_toggle_encoder.sv
module bitstream_toggle_encoder
  import enc_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout,
  output logic inv_mode
);

  logic       rst_sync_n;
  enc_state_e state_q;
  enc_state_e state_d;

  enc_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  enc_next_state u_next (
    .state_q (state_q),
    .din     (din),
    .state_d (state_d)
  );

  enc_state_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .din     (din),
    .state_d (state_d),
    .state_q (state_q)
  );

  enc_out u_out (
    .state_q  (state_q),
    .din      (din),
    .dout     (dout),
    .inv_mode (inv_mode)
  );

endmodule

// File: tb/tb_bitstream_toggle_encoder.sv
`timescale 1ns/1ps
module tb_bitstream_toggle_encoder;

  localparam int NBITS = 16;
  // R8 reference: first bit is the MSB
  localparam logic [NBITS-1:0] REF_IN  = 16'b0111010001110101;
  localparam logic [NBITS-1:0] REF_OUT = 16'b0111001001110011;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din = 1'b0;
  logic dout;
  logic inv_mode;
  int   total = 0;
  int   bad = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  bitstream_toggle_encoder dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .din      (din),
    .dout     (dout),
    .inv_mode (inv_mode)
  );

  task automatic check(input logic exp_d, input logic exp_m, input string req);
    total++;
    if (dout !== exp_d || inv_mode !== exp_m) begin
      bad++;
      $display("FAIL %s: dout=%b inv_mode=%b expected dout=%b inv_mode=%b",
               req, dout, inv_mode, exp_d, exp_m);
    end
  endtask

  // drive one bit away from the rising edge, sample its encoding
  task automatic send(input logic b, input logic exp_d, input logic exp_m, input string req);
    @(negedge clk);
    din = b;
    #2;
    check(exp_d, exp_m, req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    din   = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);  // synchronizer release, din held at 0
  endtask

  initial begin
    // R1: reset state, dout follows din while reset is asserted
    #2;
    din = 1'b1; #1; check(1'b1, 1'b0, "R1 reset din=1");
    din = 1'b0; #1; check(1'b0, 1'b0, "R1 reset din=0");
    do_reset();
    din = 1'b1; #1; check(1'b1, 1'b0, "R1 after release");

    // R8: reference stream walked from the table
    do_reset();
    for (int i = NBITS - 1; i >= 0; i--) begin
      send(REF_IN[i], REF_OUT[i], REF_IN[i] ^ REF_OUT[i], "R8 reference stream");
    end

    // R5 overlap, R2 completing bit passed, R3 complement, R6 reuse, R4 release
    do_reset();
    send(1'b1, 1'b1, 1'b0, "R5 run bit1");
    send(1'b1, 1'b1, 1'b0, "R5 run bit2");
    send(1'b1, 1'b1, 1'b0, "R5 run bit3");
    send(1'b1, 1'b1, 1'b0, "R5 run bit4");
    send(1'b0, 1'b0, 1'b0, "R2 completing 0 still passed");
    send(1'b1, 1'b0, 1'b1, "R3 inverted after trigger");
    send(1'b0, 1'b1, 1'b1, "R6 trigger 0 reused, completing 0 inverted");
    send(1'b1, 1'b1, 1'b0, "R4 pass after release");

    // R7: release pattern ignored in pass mode
    do_reset();
    send(1'b0, 1'b0, 1'b0, "R7 pass 0");
    send(1'b1, 1'b1, 1'b0, "R7 pass 1");
    send(1'b0, 1'b0, 1'b0, "R7 pass 0 (0,1,0 ignored)");
    send(1'b0, 1'b0, 1'b0, "R7 pass still pass");
    send(1'b1, 1'b1, 1'b0, "R7 pass 1 again");

    // R7: trigger pattern ignored in complement mode, then R4 release
    do_reset();
    send(1'b1, 1'b1, 1'b0, "R2 bit1");
    send(1'b1, 1'b1, 1'b0, "R2 bit2");
    send(1'b0, 1'b0, 1'b0, "R2 bit3");
    send(1'b1, 1'b0, 1'b1, "R7 comp 1");
    send(1'b1, 1'b0, 1'b1, "R7 comp 1");
    send(1'b0, 1'b1, 1'b1, "R7 comp 0 (1,1,0 ignored)");
    send(1'b1, 1'b0, 1'b1, "R3 comp 1");
    send(1'b0, 1'b1, 1'b1, "R4 completing 0 still inverted");
    send(1'b0, 1'b0, 1'b0, "R4 pass from next bit");

    // R1: reset asserted mid-stream in complement mode
    do_reset();
    send(1'b1, 1'b1, 1'b0, "R2 bit1");
    send(1'b1, 1'b1, 1'b0, "R2 bit2");
    send(1'b0, 1'b0, 1'b0, "R2 bit3");
    send(1'b1, 1'b0, 1'b1, "R3 comp before reset");
    @(negedge clk);
    rst_n = 1'b0;
    din   = 1'b1;
    #2;
    check(1'b1, 1'b0, "R1 async reset mid-stream");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule